// File: doc/BRIEF.md
# One-Time-Programmable Byte Write Sequencer

This block runs byte writes into a one-time-programmable array. It accepts a request that carries a 7-bit address and a data byte. It waits a short lead interval and then drives a digital programming-pulse enable high for the required burn time. After the enable drops, it waits out the worst-case fall interval. Only then does the byte take its new value. Each programmed bit is permanent, so a write can only set bits: the stored byte becomes the old byte ORed with the incoming data.

Every interval is a whole number of clock cycles. Each one is computed from the `CLK_HZ` parameter and rounded up, so no timing minimum is ever cut short. The array is held as a behavioural register model that reset clears to all zeros. Reads are combinational from a separate read address. A request that arrives while a sequence is still running is dropped, and a one-cycle error strobe reports it.

Top module: `otp_prog_seq`

## Requirements
- R1: Each completed write leaves the addressed byte equal to its previous value ORed bitwise with the request data, so bits can be set but never cleared.
- R2: Writing 0x55 and then 0xAA to the same address reads back 0xFF.
- R3: If `wrReq` is sampled high at an edge while idle, `progEn` rises exactly ceil(2 µs × CLK_HZ) cycles after that edge.
- R4: `progEn` stays high for exactly ceil(300 µs × CLK_HZ) consecutive cycles.
- R5: After `progEn` falls, `busy` stays high for exactly ceil(10 µs × CLK_HZ) more cycles. Then `busy` drops, `done` is high for exactly one cycle, and the stored byte shows its new value in that same cycle.
- R6: `busy` is high from the cycle after a request is accepted until the post-fall wait ends. While `busy` is high, `wrReq` is ignored: the array is not changed and no new sequence starts. For each cycle in which `wrReq` is high while busy, `reqErr` is high in the following cycle.
- R7: After reset, all 128 bytes read 0x00, and `busy`, `progEn`, `done` and `reqErr` are all 0.
- R8: While a write is in progress, reading its address returns the value from before the write, up to the cycle in which `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rstN | input | 1 | Asynchronous active-low reset |
| wrReq | input | 1 | Write request, sampled on the rising edge |
| wrAddr | input | 7 | Byte address of the write |
| wrData | input | 8 | Bits to set in the addressed byte |
| rdAddr | input | 7 | Read address |
| rdData | output | 8 | Stored byte at rdAddr, combinational |
| busy | output | 1 | A write sequence is running |
| progEn | output | 1 | Programming pulse enable |
| done | output | 1 | One-cycle strobe when a write completes |
| reqErr | output | 1 | One-cycle strobe for a request dropped while busy |

## Verification
The bench builds the block with CLK_HZ = 1,250,000. At that frequency the lead and fall intervals come to 2.5 and 12.5 cycles, so rounding up to 3 and 13 cycles is exercised. The pulse is 375 cycles, which keeps a full write at roughly 390 cycles, so several writes fit in a short run. A cycle-accurate reference model checks the collision case, in which a request is held high across a whole sequence. In that case the request is accepted again in the same cycle that `done` is reported.

// File: rtl/otp_prog_pkg.sv
`timescale 1ns/1ps
package otp_prog_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_PULSE, ST_FALL} seqState_e;

  typedef struct packed {
    logic capture;
    logic commit;
  } dpStrobe_t;

  // Cycles covering at least durNs nanoseconds at hz, rounded up, minimum 1.
  function automatic int cyclesFor(longint hz, longint durNs);
    longint t;
    t = (hz * durNs + 64'd999_999_999) / 64'd1_000_000_000;
    return (t < 1) ? 1 : int'(t);
  endfunction
endpackage

// File: rtl/otp_prog_ctrl.sv
`timescale 1ns/1ps
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int LEAD_CYC  = 2,
  parameter int PULSE_CYC = 300,
  parameter int FALL_CYC  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrReq,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       progEn,
  output logic       done,
  output logic       reqErr
);
  localparam int MAX_CYC = (PULSE_CYC > LEAD_CYC) ?
                           ((PULSE_CYC > FALL_CYC) ? PULSE_CYC : FALL_CYC) :
                           ((LEAD_CYC > FALL_CYC) ? LEAD_CYC : FALL_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  seqState_e state;
  logic [CNT_W-1:0] cnt;
  logic cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      done   <= 1'b0;
      reqErr <= 1'b0;
    end else begin
      done   <= 1'b0;
      reqErr <= wrReq && (state != ST_IDLE);
      case (state)
        ST_IDLE: begin
          if (wrReq) begin
            state <= ST_LEAD;
            cnt   <= CNT_W'(LEAD_CYC - 1);
          end
        end
        ST_LEAD: begin
          if (cntZero) begin
            state <= ST_PULSE;
            cnt   <= CNT_W'(PULSE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PULSE: begin
          if (cntZero) begin
            state <= ST_FALL;
            cnt   <= CNT_W'(FALL_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cntZero) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.capture = (state == ST_IDLE) && wrReq;
    strobe.commit  = (state == ST_FALL) && cntZero;
  end

  assign busy   = (state != ST_IDLE);
  assign progEn = (state == ST_PULSE);
endmodule

// File: rtl/otp_prog_mem.sv
`timescale 1ns/1ps
module otp_prog_mem
  import otp_prog_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cells [DEPTH];
  logic [ADDR_W-1:0] pendAddr;
  logic [DATA_W-1:0] pendData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      pendData <= '0;
    end else if (strobe.capture) begin
      pendAddr <= wrAddr;
      pendData <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (strobe.commit) begin
      cells[pendAddr] <= cells[pendAddr] | pendData;
    end
  end

  assign rdData = cells[rdAddr];
endmodule

// File: rtl/otp_prog_seq.sv
`timescale 1ns/1ps
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int CLK_HZ = 1_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrReq,
  input  logic [6:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [6:0] rdAddr,
  output logic [7:0] rdData,
  output logic       busy,
  output logic       progEn,
  output logic       done,
  output logic       reqErr
);
  localparam int LEAD_CYC  = cyclesFor(longint'(CLK_HZ), 64'd2_000);
  localparam int PULSE_CYC = cyclesFor(longint'(CLK_HZ), 64'd300_000);
  localparam int FALL_CYC  = cyclesFor(longint'(CLK_HZ), 64'd10_000);

  dpStrobe_t strobe;

  otp_prog_ctrl #(
    .LEAD_CYC (LEAD_CYC),
    .PULSE_CYC(PULSE_CYC),
    .FALL_CYC (FALL_CYC)
  ) ctrl_i (
    .clk   (clk),
    .rstN  (rstN),
    .wrReq (wrReq),
    .strobe(strobe),
    .busy  (busy),
    .progEn(progEn),
    .done  (done),
    .reqErr(reqErr)
  );

  otp_prog_mem #(
    .DEPTH (128),
    .DATA_W(8)
  ) mem_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );
endmodule

// File: rtl/otp_prog_chk.sv
`timescale 1ns/1ps
module otp_prog_chk #(
  parameter int PULSE_CYC = 300
) (
  input logic       clk,
  input logic       rstN,
  input logic [6:0] rdAddr,
  input logic [7:0] rdData,
  input logic       busy,
  input logic       progEn,
  input logic       done,
  input logic       reqErr
);
  int highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) highRun <= 0;
    else if (progEn) highRun <= highRun + 1;
    else highRun <= 0;
  end

  AST_PULSE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rstN) progEn |-> busy); // R4
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN) $fell(progEn) |-> highRun == PULSE_CYC); // R4
  AST_PULSE_AFTER_LEAD: assert property (@(posedge clk) disable iff (!rstN) $rose(progEn) |-> $past(busy)); // R3
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R5
  AST_ERR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN) reqErr |-> $past(busy)); // R6
  AST_READ_HOLDS_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && rdAddr == $past(rdAddr)) |-> rdData == $past(rdData)); // R8
endmodule

bind otp_prog_seq otp_prog_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .rdAddr(rdAddr),
  .rdData(rdData),
  .busy  (busy),
  .progEn(progEn),
  .done  (done),
  .reqErr(reqErr)
);

// File: tb/otp_prog_seq_tb_top.sv
`timescale 1ns/1ps
module otp_prog_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HZ    = 1_250_000;
  localparam int LEAD  = 3;    // ceil(2.5)
  localparam int PULSE = 375;  // 300 us
  localparam int FALL  = 13;   // ceil(12.5)
  localparam int TOT   = LEAD + PULSE + FALL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrReq = 1'b0;
  logic [6:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [6:0] rdAddr = '0;
  logic [7:0] rdData;
  logic busy, progEn, done, reqErr;

  int total = 0;
  int failed = 0;
  bit started = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  otp_prog_seq #(.CLK_HZ(HZ)) dut_i (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .progEn(progEn),
    .done(done), .reqErr(reqErr)
  );

  // Reference model: n counts edges since acceptance, -1 when idle.
  int n = -1;
  logic [6:0] mAddr;
  logic [7:0] mData;
  logic [7:0] mMem [128];
  logic mDone = 1'b0;
  logic mErr = 1'b0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      n = -1; mDone = 0; mErr = 0;
      for (int i = 0; i < 128; i++) mMem[i] = 8'h00;
    end else begin
      started = 1;
      mDone = 0;
      mErr = 0;
      if (n < 0) begin
        if (wrReq) begin n = 0; mAddr = wrAddr; mData = wrData; end
      end else begin
        if (wrReq) mErr = 1;
        n++;
        if (n == TOT) begin
          mMem[mAddr] = mMem[mAddr] | mData;
          mDone = 1;
          n = -1;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (started && rstN) begin
      chk("R6 busy", {7'b0, busy}, {7'b0, n >= 0});
      chk("R3,R4 progEn", {7'b0, progEn}, {7'b0, (n >= LEAD) && (n < LEAD + PULSE)});
      chk("R5 done", {7'b0, done}, {7'b0, mDone});
      chk("R6 reqErr", {7'b0, reqErr}, {7'b0, mErr});
      chk("R1,R8 rdData", rdData, mMem[rdAddr]);
    end
  end

  task automatic issue(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wrReq = 1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrReq = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < TOT + 3; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failed++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    chk("R7 busy", {7'b0, busy}, 8'h0);
    chk("R7 progEn", {7'b0, progEn}, 8'h0);
    chk("R7 done", {7'b0, done}, 8'h0);
    chk("R7 reqErr", {7'b0, reqErr}, 8'h0);
    for (int a = 0; a < 128; a++) begin
      rdAddr = 7'(a); #1;
      chk("R7 erased", rdData, 8'h00);
    end

    // R2: 0x55 then 0xAA at 0x71
    rdAddr = 7'h71;
    issue(7'h71, 8'h55); waitIdle();
    #1 chk("R1 first write", rdData, 8'h55);
    issue(7'h71, 8'hAA); waitIdle();
    #1 chk("R2 or readback", rdData, 8'hFF);

    // R8 and R6: read during write, collide while busy
    rdAddr = 7'h05;
    issue(7'h05, 8'h0F);
    #1 chk("R8 old value at start", rdData, 8'h00);
    @(negedge clk);
    wrReq = 1; wrAddr = 7'h05; wrData = 8'hF0;
    @(negedge clk); wrReq = 0;
    repeat (LEAD + 10) @(negedge clk);
    wrReq = 1; wrAddr = 7'h06; wrData = 8'hFF;
    @(negedge clk); wrReq = 0;
    #1 chk("R8 old value in pulse", rdData, 8'h00);
    waitIdle();
    #1 chk("R6 dropped request ignored", rdData, 8'h0F);
    rdAddr = 7'h06; #1;
    chk("R6 second dropped ignored", rdData, 8'h00);

    // R1: further OR on same byte
    rdAddr = 7'h05;
    issue(7'h05, 8'h30); waitIdle();
    #1 chk("R1 accumulate", rdData, 8'h3F);

    // Request held high across sequences: re-accepted on the done cycle
    rdAddr = 7'h09;
    @(negedge clk);
    wrReq = 1; wrAddr = 7'h09; wrData = 8'h81;
    for (int i = 0; i < 2 * TOT + 4; i++) @(negedge clk);
    wrReq = 0;
    waitIdle();
    #1 chk("R1 held request", rdData, 8'h81);

    repeat (4) @(negedge clk);
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule